// File: doc/BRIEF.md
# Page Migration Access Monitor

This block watches memory accesses page by page and tells a local processor when a page would be better placed nearer to it. For each page it keeps two saturating counters: one for accesses made by the local requester and one for accesses made by the page's home node. Each local access is followed by a comparison. Once the local count leads the home count by more than a programmable threshold, the page index is queued as a migration interrupt. The interrupt is offered through a valid/acknowledge handshake.

Each page also carries a poison flag. A copy engine sets it once the page has been moved away. While the flag is set, an access to that page is answered with a bus-error pulse and the page index, and the counters are not touched. This lets stale address translations be dropped lazily, when they are next used. Software or the copy engine clears the counters of a page with a clear strobe. Only an explicit unpoison write removes the poison flag.

Top module: `pmc_migration_monitor`

## Requirements
- R1: After reset all counters are zero, no page is pending or poisoned, `irq_valid` is 0 and `buserr` is 0.
- R2: An accepted access (`acc_valid`=1 to a page that is not poisoned) adds one to that page's home counter when `acc_is_home`=1 and to its local counter when `acc_is_home`=0.
- R3: Only a local access triggers the comparison. The page is queued when, after the increment, local count minus home count is strictly greater than `threshold`, and `irq_valid` shows it from the cycle after the access.
- R4: Counters saturate at 2^CNT_W-1 and never wrap.
- R5: A page that has been queued raises no further interrupt until its counters are cleared, even after its interrupt is acknowledged.
- R6: `clr_valid` zeroes both counters of `clr_page` and drops its pending mark, but leaves its poison flag unchanged. When the clear and an access hit the same page in the same cycle, the clear wins and the access is not counted.
- R7: A `pz_valid` write sets the poison flag of `pz_page` when `pz_set`=1 and clears it when `pz_set`=0.
- R8: An access to a poisoned page drives `buserr`=1 with `buserr_page` equal to the page in the following cycle. It changes no counter and raises no interrupt.
- R9: Up to two interrupts are held in arrival order. `irq_page` shows the oldest, and `irq_ack` while `irq_valid` removes it. An acknowledge with no interrupt held has no effect.
- R10: When two interrupts are already held, a newly qualifying page is not queued and not marked pending. A later local access to that page queues it once there is room.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Memory access event strobe |
| acc_page | input | PG_W | Page index of the access |
| acc_is_home | input | 1 | 1: access by the home node, 0: local access |
| threshold | input | CNT_W | Programmable lead that local accesses must exceed |
| pz_valid | input | 1 | Poison flag write strobe |
| pz_page | input | PG_W | Page whose poison flag is written |
| pz_set | input | 1 | 1 sets poison, 0 clears it |
| clr_valid | input | 1 | Counter clear strobe |
| clr_page | input | PG_W | Page whose counters are cleared |
| irq_valid | output | 1 | A migration interrupt is held |
| irq_page | output | PG_W | Page of the oldest held interrupt |
| irq_ack | input | 1 | Acknowledge, removes the oldest interrupt |
| buserr | output | 1 | The access one cycle earlier hit a poisoned page |
| buserr_page | output | PG_W | Page of that access |

## Verification
The bench builds the block with four pages and 4-bit counters. At that size the saturation point of 15 is reached in a few accesses. Home saturation is shown with a zero threshold: with wrapping counters, a small local lead would fire the interrupt, and with saturating counters the lead never appears. Four pages are enough to fill the two-entry interrupt queue and still have a third page waiting on a full queue. The threshold changes during the run, so both the strict comparison boundary and the zero-threshold case are covered.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
    localparam int DEF_PAGES = 16;
    localparam int DEF_CNT_W = 8;
    localparam int IRQ_DEPTH = 2;

    typedef enum logic {
        SRC_LOCAL = 1'b0,
        SRC_HOME  = 1'b1
    } src_e;

    typedef enum logic [1:0] {
        ACC_IDLE   = 2'd0,
        ACC_COUNT  = 2'd1,
        ACC_POISON = 2'd2,
        ACC_DROP   = 2'd3
    } acc_kind_e;
endpackage

// File: rtl/pmc_count_bank.sv
module pmc_count_bank
    import pmc_pkg::*;
#(
    parameter int NUM_PAGES = DEF_PAGES,
    parameter int CNT_W     = DEF_CNT_W,
    localparam int PG_W     = $clog2(NUM_PAGES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc_valid,
    input  logic [PG_W-1:0]  inc_page,
    input  src_e             inc_src,
    input  logic             clr_valid,
    input  logic [PG_W-1:0]  clr_page,
    output logic [CNT_W-1:0] loc_next,
    output logic [CNT_W-1:0] home_next
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] loc_q  [NUM_PAGES];
    logic [CNT_W-1:0] home_q [NUM_PAGES];

    function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
        return (v == CNT_MAX) ? v : v + 1'b1;
    endfunction

    always_comb begin
        loc_next  = loc_q[inc_page];
        home_next = home_q[inc_page];
        if (inc_src == SRC_HOME) home_next = sat_inc(home_q[inc_page]);
        else                     loc_next  = sat_inc(loc_q[inc_page]);
    end

    for (genvar g = 0; g < NUM_PAGES; g++) begin : g_page
        logic hit_clr, hit_inc;
        assign hit_clr = clr_valid && (clr_page == PG_W'(g));
        assign hit_inc = inc_valid && (inc_page == PG_W'(g));
        always_ff @(posedge clk) begin
            if (rst || hit_clr) begin
                loc_q[g]  <= '0;
                home_q[g] <= '0;
            end else if (hit_inc) begin
                loc_q[g]  <= loc_next;
                home_q[g] <= home_next;
            end
        end
    end
endmodule

// File: rtl/pmc_poison_table.sv
module pmc_poison_table
    import pmc_pkg::*;
#(
    parameter int NUM_PAGES = DEF_PAGES,
    localparam int PG_W     = $clog2(NUM_PAGES)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_valid,
    input  logic [PG_W-1:0]      wr_page,
    input  logic                 wr_set,
    output logic [NUM_PAGES-1:0] poisoned
);
    for (genvar g = 0; g < NUM_PAGES; g++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)                                      poisoned[g] <= 1'b0;
            else if (wr_valid && wr_page == PG_W'(g))     poisoned[g] <= wr_set;
        end
    end
endmodule

// File: rtl/pmc_irq_fifo.sv
module pmc_irq_fifo
    import pmc_pkg::*;
#(
    parameter int WIDTH = 4,
    parameter int DEPTH = IRQ_DEPTH,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic             full,
    output logic             not_empty,
    output logic [WIDTH-1:0] head
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] rd_ptr, wr_ptr;
    logic [CNT_W-1:0] count;
    logic             do_push, do_pop;

    assign full      = (count == CNT_W'(DEPTH));
    assign not_empty = (count != '0);
    assign head      = mem[rd_ptr];
    assign do_push   = push && !full;
    assign do_pop    = pop && not_empty;

    function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= nxt(wr_ptr);
            if (do_pop)  rd_ptr <= nxt(rd_ptr);
            if (do_push && !do_pop)      count <= count + 1'b1;
            else if (do_pop && !do_push) count <= count - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end
endmodule

// File: rtl/pmc_migration_monitor.sv
module pmc_migration_monitor
    import pmc_pkg::*;
#(
    parameter int NUM_PAGES = DEF_PAGES,
    parameter int CNT_W     = DEF_CNT_W,
    localparam int PG_W     = $clog2(NUM_PAGES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             acc_valid,
    input  logic [PG_W-1:0]  acc_page,
    input  logic             acc_is_home,
    input  logic [CNT_W-1:0] threshold,
    input  logic             pz_valid,
    input  logic [PG_W-1:0]  pz_page,
    input  logic             pz_set,
    input  logic             clr_valid,
    input  logic [PG_W-1:0]  clr_page,
    output logic             irq_valid,
    output logic [PG_W-1:0]  irq_page,
    input  logic             irq_ack,
    output logic             buserr,
    output logic [PG_W-1:0]  buserr_page
);
    logic [NUM_PAGES-1:0] poisoned;
    logic [NUM_PAGES-1:0] pending;
    logic [CNT_W-1:0]     loc_next, home_next;
    logic [CNT_W:0]       lead;
    logic                 fifo_full, fire, same_clr;
    acc_kind_e            kind;
    src_e                 src;

    assign src      = acc_is_home ? SRC_HOME : SRC_LOCAL;
    assign same_clr = clr_valid && (clr_page == acc_page);

    always_comb begin
        if (!acc_valid)              kind = ACC_IDLE;
        else if (poisoned[acc_page]) kind = ACC_POISON;
        else if (same_clr)           kind = ACC_DROP;
        else                         kind = ACC_COUNT;
    end

    pmc_poison_table #(.NUM_PAGES(NUM_PAGES)) u_poison (
        .clk(clk), .rst(rst),
        .wr_valid(pz_valid), .wr_page(pz_page), .wr_set(pz_set),
        .poisoned(poisoned)
    );

    pmc_count_bank #(.NUM_PAGES(NUM_PAGES), .CNT_W(CNT_W)) u_counts (
        .clk(clk), .rst(rst),
        .inc_valid(kind == ACC_COUNT), .inc_page(acc_page), .inc_src(src),
        .clr_valid(clr_valid), .clr_page(clr_page),
        .loc_next(loc_next), .home_next(home_next)
    );

    assign lead = {1'b0, loc_next} - {1'b0, home_next};
    assign fire = (kind == ACC_COUNT) && (src == SRC_LOCAL)
               && (loc_next > home_next) && (lead > {1'b0, threshold})
               && !pending[acc_page] && !fifo_full;

    for (genvar g = 0; g < NUM_PAGES; g++) begin : g_pend
        always_ff @(posedge clk) begin
            if (rst || (clr_valid && clr_page == PG_W'(g)))  pending[g] <= 1'b0;
            else if (fire && acc_page == PG_W'(g))          pending[g] <= 1'b1;
        end
    end

    pmc_irq_fifo #(.WIDTH(PG_W), .DEPTH(IRQ_DEPTH)) u_irq (
        .clk(clk), .rst(rst),
        .push(fire), .push_data(acc_page),
        .pop(irq_ack),
        .full(fifo_full), .not_empty(irq_valid), .head(irq_page)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            buserr      <= 1'b0;
            buserr_page <= '0;
        end else begin
            buserr <= (kind == ACC_POISON);
            if (kind == ACC_POISON) buserr_page <= acc_page;
        end
    end
endmodule

// File: rtl/pmc_checker.sv
module pmc_checker #(
    parameter int NUM_PAGES = 16,
    parameter int CNT_W     = 8,
    localparam int PG_W     = $clog2(NUM_PAGES)
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 acc_valid,
    input logic [PG_W-1:0]      acc_page,
    input logic                 acc_is_home,
    input logic                 irq_valid,
    input logic [PG_W-1:0]      irq_page,
    input logic                 irq_ack,
    input logic                 buserr,
    input logic [PG_W-1:0]      buserr_page,
    input logic [NUM_PAGES-1:0] poisoned
);
    // R3: a new interrupt appears only after a local access
    a_r3_irq_from_local: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_valid) |-> $past(acc_valid && !acc_is_home));

    // R9: the oldest interrupt stays put until acknowledged
    a_r9_hold_until_ack: assert property (@(posedge clk) disable iff (rst)
        (irq_valid && !irq_ack) |=> (irq_valid && $stable(irq_page)));

    // R9: the queue empties only through an acknowledge
    a_r9_drain_by_ack: assert property (@(posedge clk) disable iff (rst)
        $fell(irq_valid) |-> $past(irq_ack));

    // R8: a bus error answers an access to a page that was poisoned
    a_r8_buserr_cause: assert property (@(posedge clk) disable iff (rst)
        buserr |-> ($past(acc_valid) && $past(poisoned[acc_page])
                    && buserr_page == $past(acc_page)));

    // R8: an access to a poisoned page always yields a bus error
    a_r8_buserr_follows: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && poisoned[acc_page]) |=> buserr);
endmodule

bind pmc_migration_monitor pmc_checker #(.NUM_PAGES(NUM_PAGES), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst),
    .acc_valid(acc_valid), .acc_page(acc_page), .acc_is_home(acc_is_home),
    .irq_valid(irq_valid), .irq_page(irq_page), .irq_ack(irq_ack),
    .buserr(buserr), .buserr_page(buserr_page),
    .poisoned(poisoned)
);

// File: tb/test_pmc_migration_monitor.sv
module test_pmc_migration_monitor;
    localparam int NP   = 4;
    localparam int CW   = 4;
    localparam int PW   = $clog2(NP);
    localparam int CMAX = (1 << CW) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic acc_valid = 1'b0, acc_is_home = 1'b0;
    logic [PW-1:0] acc_page = '0;
    logic [CW-1:0] threshold = CW'(3);
    logic pz_valid = 1'b0, pz_set = 1'b0, clr_valid = 1'b0, irq_ack = 1'b0;
    logic [PW-1:0] pz_page = '0, clr_page = '0;
    logic irq_valid, buserr;
    logic [PW-1:0] irq_page, buserr_page;

    always #2 clk = ~clk;

    pmc_migration_monitor #(.NUM_PAGES(NP), .CNT_W(CW)) i_pmc_migration_monitor (
        .clk(clk), .rst(rst),
        .acc_valid(acc_valid), .acc_page(acc_page), .acc_is_home(acc_is_home),
        .threshold(threshold),
        .pz_valid(pz_valid), .pz_page(pz_page), .pz_set(pz_set),
        .clr_valid(clr_valid), .clr_page(clr_page),
        .irq_valid(irq_valid), .irq_page(irq_page), .irq_ack(irq_ack),
        .buserr(buserr), .buserr_page(buserr_page)
    );

    int checks = 0, errors = 0;
    int loc [NP], hom [NP];
    bit pend [NP], psn [NP];
    int exp_q [$];

    task automatic chk(input string req, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // monitor side of the scoreboard: compare irq outputs with queued expectations
    task automatic mon_irq(input string req);
        chk(req, irq_valid, exp_q.size() != 0, "irq_valid");
        if (exp_q.size() != 0) chk(req, irq_page, exp_q[0], "irq_page");
    endtask

    // driver: one access per cycle, model pushes expected items
    task automatic access(input int p, input bit home, input string req);
        bit perr;
        @(negedge clk);
        acc_valid = 1'b1; acc_page = PW'(p); acc_is_home = home;
        perr = psn[p];
        if (!perr) begin
            if (home) begin if (hom[p] < CMAX) hom[p]++; end
            else begin
                if (loc[p] < CMAX) loc[p]++;
                if (loc[p] - hom[p] > int'(threshold) && !pend[p] && exp_q.size() < 2) begin
                    exp_q.push_back(p);
                    pend[p] = 1'b1;
                end
            end
        end
        @(negedge clk);
        acc_valid = 1'b0;
        chk(req, buserr, perr, "buserr");
        if (perr) chk(req, buserr_page, p, "buserr_page");
        mon_irq(req);
    endtask

    task automatic ack(input string req);
        @(negedge clk);
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
        if (exp_q.size() != 0) void'(exp_q.pop_front());
        mon_irq(req);
    endtask

    task automatic clear(input int p);
        @(negedge clk);
        clr_valid = 1'b1; clr_page = PW'(p);
        loc[p] = 0; hom[p] = 0; pend[p] = 1'b0;
        @(negedge clk);
        clr_valid = 1'b0;
    endtask

    task automatic poison(input int p, input bit v);
        @(negedge clk);
        pz_valid = 1'b1; pz_page = PW'(p); pz_set = v;
        psn[p] = v;
        @(negedge clk);
        pz_valid = 1'b0;
    endtask

    initial begin
        #40000;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < NP; i++) begin loc[i] = 0; hom[i] = 0; pend[i] = 0; psn[i] = 0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", irq_valid, 0, "irq_valid after reset");
        chk("R1", buserr, 0, "buserr after reset");

        // R3: threshold 3 strict; fires on the 4th local access
        for (int k = 0; k < 3; k++) access(1, 1'b0, "R3");
        chk("R3", irq_valid, 0, "no irq at lead equal to threshold");
        access(1, 1'b0, "R3");
        chk("R3", irq_valid, 1, "irq once lead exceeds threshold");
        // R5: still pending, more local access no second entry
        for (int k = 0; k < 3; k++) access(1, 1'b0, "R5");
        ack("R9");
        access(1, 1'b0, "R5");
        chk("R5", irq_valid, 0, "no repeat after ack without clear");

        // R2: home accesses raise the bar
        access(2, 1'b1, "R2");
        access(2, 1'b1, "R2");
        for (int k = 0; k < 5; k++) access(2, 1'b0, "R2");
        chk("R2", irq_valid, 0, "lead 3 after two home accesses");
        access(2, 1'b0, "R2");
        chk("R2", irq_page, 2, "page 2 queued at lead 4");

        // R10 / R9: fill queue with page 3, page 0 waits
        for (int k = 0; k < 4; k++) access(3, 1'b0, "R9");
        for (int k = 0; k < 5; k++) access(0, 1'b0, "R10");
        ack("R9");
        chk("R9", irq_page, 3, "second entry in order");
        access(0, 1'b0, "R10");
        ack("R9");
        chk("R10", irq_page, 0, "page 0 queued after room");
        ack("R9");
        ack("R9");
        chk("R9", irq_valid, 0, "ack on empty queue ignored");

        // R6: clear re-arms page 1
        clear(1);
        for (int k = 0; k < 4; k++) access(1, 1'b0, "R6");
        chk("R6", irq_page, 1, "page 1 fires again after clear");
        ack("R9");

        // R4: home saturates; zero threshold would fire if it wrapped
        threshold = '0;
        clear(2);
        for (int k = 0; k < 17; k++) access(2, 1'b1, "R4");
        for (int k = 0; k < 17; k++) access(2, 1'b0, "R4");
        chk("R4", irq_valid, 0, "saturated counters give no lead");

        // R7 / R8: poison blocks counting and gives bus error
        clear(3);
        poison(3, 1'b1);
        access(3, 1'b0, "R8");
        chk("R8", buserr, 1, "buserr on poisoned page");
        clear(3);
        access(3, 1'b0, "R6");
        chk("R6", buserr, 1, "clear keeps poison");
        poison(3, 1'b0);
        access(3, 1'b0, "R7");
        chk("R7", buserr, 0, "unpoison restores access");
        chk("R8", irq_page, 3, "poisoned accesses not counted, first real one fires");
        ack("R9");

        // R6: clear and access same page same cycle: clear wins
        clear(0);
        @(negedge clk);
        clr_valid = 1'b1; clr_page = PW'(0);
        acc_valid = 1'b1; acc_page = PW'(0); acc_is_home = 1'b0;
        @(negedge clk);
        clr_valid = 1'b0; acc_valid = 1'b0;
        mon_irq("R6");
        access(0, 1'b1, "R6");
        access(0, 1'b0, "R6");
        chk("R6", irq_valid, 0, "collided access not counted");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule